// File: doc/BRIEF.md
# Multi-output video line buffer

This block keeps the most recent lines of a video stream in one shared on-chip store. It presents a vertical window of those lines, or kernel, to several consumers at the same time. Each consumer port has its own kernel height and its own start position in the store. Positions are counted from the oldest line held. A filter stage placed after a port receives, on each beat, one pixel column of its kernel, with every kernel line side by side on separate lanes.

The block is driven by a command word. It holds a shift flag and a port-enable mask. With the shift flag set, the block takes in one full input line of `LINE_PIX` pixels and appends it as the newest line. The oldest line is dropped. The mask chooses which ports emit their kernel during the same pass. When the shift flag is clear, the kernel already stored is emitted again without change. An upscaling stage uses this to build several output lines from one input window.

A command is only taken while the block is idle. A pass lasts one line. When it ends, the block is ready for the next command.

Top module: `line_fanout_buf`

## Requirements
- R1: After reset, `cmd_ready` is 1, `in_ready` is 0 and every bit of `out_valid` is 0.
- R2: A command with the shift flag set and an all-zero mask takes exactly `LINE_PIX` input pixels through `in_ready`/`in_valid`, and no port raises `out_valid` during that pass.
- R3: A port whose mask bit is set emits `LINE_PIX` beats, one per pixel. `out_sop` is set on pixel 0 and `out_eop` on pixel `LINE_PIX-1`. A port whose mask bit is clear keeps `out_valid` at 0. Bit k of every per-port vector belongs to port k.
- R4: Line 0 of the store is the oldest line and line DEPTH-1 is the newest. Lane j of port k (bits `(k*KMAX+j)*PIX_W` upward in `out_lanes`) carries line `OFF_k + j` for j below the kernel height `KS_k`. Lanes at or above `KS_k` carry zero. Port 0 always starts at line 0.
- R5: In a pass that both shifts and sends, the kernel already includes the line being written, as line DEPTH-1. Each output beat appears one clock after its input pixel is accepted.
- R6: A send without a shift emits the same kernel contents as the pass before it, and the store is left unchanged.
- R7: Lines not yet written since reset read as zero on every lane.
- R8: DEPTH equals the largest value of start offset plus kernel height over all ports (16 by default). Once more than DEPTH lines have been shifted in, line 0 is the line shifted in DEPTH shifts ago.
- R9: In a shifting pass, a cycle with `in_valid` low produces no output beat and does not advance the pixel position.
- R10: `cmd_ready` is 0 for the whole of a pass and 1 again on the cycle after its last beat. A command with the shift flag clear and an all-zero mask is taken and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken this cycle |
| cmd_shift | input | 1 | Take in a new line this pass |
| cmd_mask | input | N_OUT | Ports that emit their kernel this pass |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel taken this cycle |
| in_pix | input | PIX_W | Input pixel |
| out_valid | output | N_OUT | Per-port beat valid |
| out_sop | output | N_OUT | Per-port first beat of kernel packet |
| out_eop | output | N_OUT | Per-port last beat of kernel packet |
| out_lanes | output | N_OUT*KMAX*PIX_W | Per-port kernel column, one lane per line |

## Verification
The hardest situation to reach is one where three things happen together. The circular store has wrapped several times, the newest line is being forwarded straight from the input while its slot is overwritten, and the input stalls partway through that same pass. The bench gets there in stages. It first shifts a few lines with no port enabled and sends over a partly filled store. It then shifts more than DEPTH lines, varying the enable masks. Finally it runs a shifting pass with a gap inserted in `in_valid`, and compares every lane against a model of which line each window position should hold.

// File: rtl/lbf_pkg.sv
// Package: shared helpers for the multi-output line buffer.
// Port geometry arrives as packed vectors of 8-bit fields, port 0 in the low byte.
package lbf_pkg;

    localparam int FIELD_W = 8;
    localparam int MAX_PORTS = 32;

    // Read 8-bit field i from a packed parameter vector.
    function automatic int unsigned field8(logic [MAX_PORTS*FIELD_W-1:0] v, int i);
        return int'(v[i*FIELD_W +: FIELD_W]);
    endfunction

    // Store depth: largest start plus height; port 0 start forced to zero.
    function automatic int unsigned calc_depth(int n, logic [MAX_PORTS*FIELD_W-1:0] offs,
                                               logic [MAX_PORTS*FIELD_W-1:0] ks);
        int unsigned d;
        d = 1;
        for (int i = 0; i < n; i++) begin
            int unsigned e;
            e = ((i == 0) ? 0 : field8(offs, i)) + field8(ks, i);
            if (e > d) d = e;
        end
        return d;
    endfunction

    // Widest kernel over all ports, which sets the lane count per port.
    function automatic int unsigned calc_kmax(int n, logic [MAX_PORTS*FIELD_W-1:0] ks);
        int unsigned m;
        m = 1;
        for (int i = 0; i < n; i++) begin
            if (field8(ks, i) > m) m = field8(ks, i);
        end
        return m;
    endfunction

endpackage

// File: rtl/lbf_seq.sv
// Module: lbf_seq
// Sequences one line-long pass per command: accepts a command when idle,
// steps the pixel position, and stalls on missing input in shifting passes.
// Assumes LINE_PIX >= 2.
module lbf_seq #(
    parameter int N_OUT    = 5,
    parameter int LINE_PIX = 8,
    localparam int PIX_IW  = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_shift,
    input  logic [N_OUT-1:0]  cmd_mask,
    input  logic              in_valid,
    output logic              cmd_ready,
    output logic              in_ready,
    output logic              step,
    output logic              shift_q,
    output logic [N_OUT-1:0]  mask_q,
    output logic [PIX_IW-1:0] pix_idx,
    output logic              at_first,
    output logic              at_last,
    output logic              commit
);

    logic busy;

    // Pass state: latch command when idle, advance pixel position while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shift_q <= 1'b0;
            mask_q  <= '0;
            pix_idx <= '0;
        end else if (!busy) begin
            if (cmd_valid && (cmd_shift || (|cmd_mask))) begin
                busy    <= 1'b1;
                shift_q <= cmd_shift;
                mask_q  <= cmd_mask;
                pix_idx <= '0;
            end
        end else if (step) begin
            if (at_last) begin
                busy    <= 1'b0;
                pix_idx <= '0;
            end else begin
                pix_idx <= pix_idx + 1'b1;
            end
        end
    end

    // Handshakes and per-pixel strobes derived from the pass state.
    always_comb begin
        cmd_ready = !busy;
        in_ready  = busy && shift_q;
        step      = busy && (!shift_q || in_valid);
        at_first  = (pix_idx == '0);
        at_last   = (pix_idx == PIX_IW'(LINE_PIX - 1));
        commit    = step && at_last && shift_q;
    end

endmodule

// File: rtl/lbf_store.sv
// Module: lbf_store
// Circular store of DEPTH line slots with a head pointer at the oldest slot.
// Presents all lines in age order (line 0 oldest) at the current pixel.
// During a shifting pass the view is already advanced, and the newest line
// is forwarded from the input pixel. Unwritten slots read as zero.
module lbf_store #(
    parameter int DEPTH    = 16,
    parameter int LINE_PIX = 8,
    parameter int PIX_W    = 8,
    localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PIX_IW  = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PIX_IW-1:0]      pix_idx,
    input  logic                   wr_en,
    input  logic [PIX_W-1:0]       wr_pix,
    input  logic                   shifting,
    input  logic                   commit,
    output logic [DEPTH*PIX_W-1:0] view
);

    logic [PIX_W-1:0]  mem [DEPTH][LINE_PIX];
    logic [DEPTH-1:0]  filled;
    logic [SLOT_W-1:0] head;
    logic [SLOT_W-1:0] head_nx;
    logic [SLOT_W-1:0] base;

    // Next head position with wrap at DEPTH.
    always_comb begin
        head_nx = (head == SLOT_W'(DEPTH - 1)) ? '0 : head + 1'b1;
        base    = shifting ? head_nx : head;
    end

    // Pixel write into the slot being replaced.
    always_ff @(posedge clk) begin
        if (wr_en) mem[head][pix_idx] <= wr_pix;
    end

    // Head advance and fill tracking at the end of each shifting pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            filled <= '0;
        end else if (commit) begin
            filled[head] <= 1'b1;
            head         <= head_nx;
        end
    end

    // Age-ordered read of every line at the current pixel.
    always_comb begin
        for (int l = 0; l < DEPTH; l++) begin
            logic [SLOT_W:0]   sum;
            logic [SLOT_W-1:0] idx;
            sum = {1'b0, base} + (SLOT_W + 1)'(l);
            if (sum >= (SLOT_W + 1)'(DEPTH)) sum = sum - (SLOT_W + 1)'(DEPTH);
            idx = sum[SLOT_W-1:0];
            if (shifting && (l == DEPTH - 1))
                view[l*PIX_W +: PIX_W] = wr_pix;
            else if (filled[idx])
                view[l*PIX_W +: PIX_W] = mem[idx][pix_idx];
            else
                view[l*PIX_W +: PIX_W] = '0;
        end
    end

endmodule

// File: rtl/lbf_tap.sv
// Module: lbf_tap
// One output port: registers its kernel window as KMAX lanes plus framing.
// Lanes at and above KS are held at zero. Assumes KS <= KMAX.
module lbf_tap #(
    parameter int PIX_W = 8,
    parameter int KS    = 4,
    parameter int KMAX  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [KS*PIX_W-1:0]   win,
    input  logic                  fire,
    input  logic                  first,
    input  logic                  last,
    output logic                  valid,
    output logic                  sop,
    output logic                  eop,
    output logic [KMAX*PIX_W-1:0] lanes
);

    logic [KMAX*PIX_W-1:0] pick;

    // Map window lines onto lanes, zero-filling beyond the kernel height.
    for (genvar j = 0; j < KMAX; j++) begin : g_lane
        if (j < KS) begin : g_live
            assign pick[j*PIX_W +: PIX_W] = win[j*PIX_W +: PIX_W];
        end else begin : g_pad
            assign pick[j*PIX_W +: PIX_W] = '0;
        end
    end

    // Output register: one beat per fired pixel, one cycle after the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            sop   <= 1'b0;
            eop   <= 1'b0;
            lanes <= '0;
        end else begin
            valid <= fire;
            sop   <= fire && first;
            eop   <= fire && last;
            if (fire) lanes <= pick;
        end
    end

endmodule

// File: rtl/line_fanout_buf.sv
// Module: line_fanout_buf
// Shared line store fanning a per-port kernel out to N_OUT ports.
// OFFS and KSIZ hold one 8-bit field per port, port 0 in the low byte.
// The start field of port 0 is ignored: port 0 always starts at line 0.
module line_fanout_buf
    import lbf_pkg::*;
#(
    parameter int N_OUT    = 5,
    parameter int PIX_W    = 8,
    parameter int LINE_PIX = 8,
    parameter logic [N_OUT*8-1:0] OFFS = {8'd1, 8'd2, 8'd7, 8'd6, 8'd0},
    parameter logic [N_OUT*8-1:0] KSIZ = {8'd12, 8'd12, 8'd1, 8'd4, 8'd16},
    localparam int DEPTH  = int'(calc_depth(N_OUT, (MAX_PORTS*FIELD_W)'(OFFS),
                                            (MAX_PORTS*FIELD_W)'(KSIZ))),
    localparam int KMAX   = int'(calc_kmax(N_OUT, (MAX_PORTS*FIELD_W)'(KSIZ))),
    localparam int PIX_IW = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic                        cmd_shift,
    input  logic [N_OUT-1:0]            cmd_mask,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [PIX_W-1:0]            in_pix,
    output logic [N_OUT-1:0]            out_valid,
    output logic [N_OUT-1:0]            out_sop,
    output logic [N_OUT-1:0]            out_eop,
    output logic [N_OUT*KMAX*PIX_W-1:0] out_lanes
);

    logic              step;
    logic              shift_q;
    logic [N_OUT-1:0]  mask_q;
    logic [PIX_IW-1:0] pix_idx;
    logic              at_first;
    logic              at_last;
    logic              commit;
    logic [DEPTH*PIX_W-1:0] view;

    lbf_seq #(.N_OUT(N_OUT), .LINE_PIX(LINE_PIX)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_shift (cmd_shift),
        .cmd_mask  (cmd_mask),
        .in_valid  (in_valid),
        .cmd_ready (cmd_ready),
        .in_ready  (in_ready),
        .step      (step),
        .shift_q   (shift_q),
        .mask_q    (mask_q),
        .pix_idx   (pix_idx),
        .at_first  (at_first),
        .at_last   (at_last),
        .commit    (commit)
    );

    lbf_store #(.DEPTH(DEPTH), .LINE_PIX(LINE_PIX), .PIX_W(PIX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_idx  (pix_idx),
        .wr_en    (step && shift_q),
        .wr_pix   (in_pix),
        .shifting (shift_q),
        .commit   (commit),
        .view     (view)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_port
        localparam int OFF_K = (k == 0) ? 0 : int'(OFFS[k*8 +: 8]);
        localparam int KS_K  = int'(KSIZ[k*8 +: 8]);

        lbf_tap #(.PIX_W(PIX_W), .KS(KS_K), .KMAX(KMAX)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .win   (view[OFF_K*PIX_W +: KS_K*PIX_W]),
            .fire  (step && mask_q[k]),
            .first (at_first),
            .last  (at_last),
            .valid (out_valid[k]),
            .sop   (out_sop[k]),
            .eop   (out_eop[k]),
            .lanes (out_lanes[k*KMAX*PIX_W +: KMAX*PIX_W])
        );
    end

endmodule

// File: rtl/lbf_chk.sv
// Module: lbf_chk
// Protocol properties of the line buffer, observed at its ports.
module lbf_chk #(
    parameter int N_OUT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_shift,
    input logic             in_valid,
    input logic             in_ready,
    input logic [N_OUT-1:0] out_valid,
    input logic [N_OUT-1:0] out_sop,
    input logic [N_OUT-1:0] out_eop
);

    // R10: a pass waiting for input is never idle at the same time.
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cmd_ready);

    // R2: an accepted shifting command opens the input on the next cycle.
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_shift) |=> in_ready);

    // R9: a missing input pixel yields no beat on any port.
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (out_valid == '0));

    // R3: framing marks appear only on valid beats.
    p_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_sop | out_eop) & ~out_valid) == '0);

    // R3: a packet end is followed by a quiet cycle on every port.
    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_eop & out_valid)) |=> (out_valid == '0));

endmodule

bind line_fanout_buf lbf_chk #(.N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_shift (cmd_shift),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/tb_line_fanout_buf.sv
// Directed bench for line_fanout_buf with the default port geometry.
module tb_line_fanout_buf;

    localparam int CLK_PERIOD = 10;
    localparam int N_OUT      = 5;
    localparam int PIX_W      = 8;
    localparam int LINE_PIX   = 8;
    localparam int DEPTH      = 16;
    localparam int KMAX       = 16;
    localparam int OFF_T [N_OUT] = '{0, 6, 7, 2, 1};
    localparam int KS_T  [N_OUT] = '{16, 4, 1, 12, 12};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_shift = 1'b0;
    logic [N_OUT-1:0] cmd_mask = '0;
    logic in_valid = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic cmd_ready;
    logic in_ready;
    logic [N_OUT-1:0] out_valid;
    logic [N_OUT-1:0] out_sop;
    logic [N_OUT-1:0] out_eop;
    logic [N_OUT*KMAX*PIX_W-1:0] out_lanes;

    int checks = 0;
    int fails = 0;
    int n_lines = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_fanout_buf dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_shift (cmd_shift),
        .cmd_mask  (cmd_mask),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_lanes (out_lanes)
    );

    // Pixel value of input line ln at pixel p; lines before the first read zero.
    function automatic logic [PIX_W-1:0] pv(int ln, int p);
        if (ln < 0) return '0;
        return PIX_W'((ln * LINE_PIX + p + 1) % 256);
    endfunction

    // Expected lane j of port k, with n_view lines stored in the window.
    function automatic logic [PIX_W-1:0] exp_lane(int n_view, int k, int j, int p);
        if (j >= KS_T[k]) return '0;
        return pv(n_view - DEPTH + OFF_T[k] + j, p);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One command pass; checks every beat. stall_at >= 0 inserts an input gap.
    task automatic run_pass(bit shift, logic [N_OUT-1:0] mask, int stall_at, string req);
        int nv;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_shift = shift;
        cmd_mask  = mask;
        @(negedge clk);
        cmd_valid = 1'b0;
        nv = shift ? n_lines + 1 : n_lines;
        for (int p = 0; p < LINE_PIX; p++) begin
            if (shift && p == stall_at) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk(out_valid == '0, "R9", "beat during input gap", int'(out_valid), 0);
                chk(in_ready == 1'b1, "R9", "input still awaited", int'(in_ready), 1);
            end
            in_valid = shift;
            in_pix   = shift ? pv(nv - 1, p) : '0;
            if (p == LINE_PIX / 2)
                chk(cmd_ready == 1'b0, "R10", "ready mid-pass", int'(cmd_ready), 0);
            @(negedge clk);
            chk(out_valid == mask, (mask == '0) ? "R2" : "R3", "out_valid",
                int'(out_valid), int'(mask));
            chk(out_sop == ((p == 0) ? mask : '0), "R3", "out_sop", int'(out_sop),
                int'((p == 0) ? mask : '0));
            chk(out_eop == ((p == LINE_PIX - 1) ? mask : '0), "R3", "out_eop",
                int'(out_eop), int'((p == LINE_PIX - 1) ? mask : '0));
            for (int k = 0; k < N_OUT; k++) begin
                if (mask[k]) begin
                    int bad_j;
                    bad_j = -1;
                    for (int j = KMAX - 1; j >= 0; j--) begin
                        if (out_lanes[(k*KMAX + j)*PIX_W +: PIX_W] != exp_lane(nv, k, j, p))
                            bad_j = j;
                    end
                    if (bad_j < 0) begin
                        chk(1'b1, req, "lanes", 0, 0);
                    end else begin
                        $display("  port %0d pixel %0d lane %0d", k, p, bad_j);
                        chk(1'b0, req, "lane value",
                            int'(out_lanes[(k*KMAX + bad_j)*PIX_W +: PIX_W]),
                            int'(exp_lane(nv, k, bad_j, p)));
                    end
                end
            end
        end
        in_valid = 1'b0;
        chk(cmd_ready == 1'b1, "R10", "ready after pass", int'(cmd_ready), 1);
        if (shift) n_lines++;
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
        chk(in_ready == 1'b0, "R1", "in_ready", int'(in_ready), 0);
        chk(out_valid == '0, "R1", "out_valid", int'(out_valid), 0);
    endtask

    task automatic t_empty_send();
        run_pass(1'b0, 5'h1F, -1, "R7");
    endtask

    task automatic t_partial_fill();
        for (int i = 0; i < 3; i++) run_pass(1'b1, 5'h00, -1, "R2");
        run_pass(1'b0, 5'h1F, -1, "R4");
    endtask

    task automatic t_noop();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_shift = 1'b0;
        cmd_mask  = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b1, "R10", "ready after empty command", int'(cmd_ready), 1);
        chk(in_ready == 1'b0, "R10", "in_ready after empty command", int'(in_ready), 0);
        @(negedge clk);
        chk(out_valid == '0, "R10", "beats after empty command", int'(out_valid), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 18; i++) begin
            logic [N_OUT-1:0] m;
            m = (i % 3 == 0) ? 5'h1F : ((i % 3 == 1) ? 5'b10101 : 5'b01010);
            run_pass(1'b1, m, -1, (n_lines < DEPTH) ? "R5" : "R8");
        end
    endtask

    task automatic t_resend();
        run_pass(1'b0, 5'h1F, -1, "R6");
        run_pass(1'b0, 5'h1F, -1, "R6");
        run_pass(1'b0, 5'b01000, -1, "R3");
    endtask

    task automatic t_stall();
        run_pass(1'b1, 5'h1F, 3, "R9");
        run_pass(1'b0, 5'b00001, -1, "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_send();
        t_partial_fill();
        t_noop();
        t_fill();
        t_resend();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule